// File: doc/BRIEF.md
# Five-Port Wormhole Router Without Virtual Channels

This block is a small input-buffered mesh router with five ports: local, east, west, north and south. Each input port has a flit FIFO. As a flit is written into that FIFO, a route unit decodes its destination coordinates with dimension-ordered XY routing and stores the result beside the flit. A head flit at the front of an idle input asks for its output port. One round-robin arbiter per output picks a single winner. The winning input then locks that output and the two stay joined by a crossbar path until the packet's tail flit crosses. Body and tail flits never go through allocation. They follow the locked path as soon as the output has downstream credit.

Each input runs a two-state machine. `IN_IDLE` means no output is held. On the **grant** transition it moves to `IN_ACTIVE` and records the output. The **tail-departure** transition takes it back to `IN_IDLE`; this happens when a tail or single-flit packet leaves the FIFO. Flow control works per flit with credits. Each output keeps a counter of free downstream slots, which starts at `CRED_INIT`. The counter goes down by one for each flit sent and up by one for each credit that comes back on `credit_in`. Each input returns a credit upstream on `credit_out` in the same cycle its FIFO releases a flit.

Top module: `wormhole_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `credit_out` are all zero.
- R2: The output port of a head flit follows XY routing against the router position (`OWN_X`, `OWN_Y`). Destination x sits in flit bits [COORD_W-1:0] and destination y in bits [2*COORD_W-1:COORD_W]. If dest x > own x the port is 1 (east). If dest x < own x the port is 2 (west). Otherwise, if dest y > own y the port is 3 (north), if dest y < own y the port is 4 (south), and if both match the port is 0 (local).
- R3: The flit type is held in bits [FLIT_W-1:FLIT_W-2], coded 00 head, 01 body, 10 tail and 11 single-flit. Take a head or single flit that arrives on an idle router. If `in_valid` is high in cycle t, the flit is on `out_valid`/`out_flit` in cycle t+3: write and route in t, allocation in t+1, traversal in t+2.
- R4: On any output, the flits of one packet come out contiguously and in order. No flit of another packet is placed between them, and a body or tail flit always follows its head's port.
- R5: A tail or single-flit packet frees its output lock when it crosses the switch, so packets from other inputs can win that output afterwards. Every packet that competes for an output is eventually delivered.
- R6: When several inputs compete for one output, at most one is granted per cycle. The priority is round-robin, so each input that was requesting is served before any input is served a second time.
- R7: An output sends no flit while its credit counter is zero. With no `credit_in` pulses it sends at most `CRED_INIT` flits, and it resumes once credits return.
- R8: `credit_out[i]` pulses exactly once per flit that leaves input FIFO i. The pulse comes in the traversal cycle, one cycle before that flit shows on the output link.
- R9: If the upstream sender keeps within `FIFO_DEPTH` credits, no flit is written into a full FIFO and no flit is lost. A packet stalled by missing downstream credit is delivered intact once credit returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | One bit per input: a flit is present on that input link |
| in_flit | input | 5*FLIT_W | Input flits, port i in bits [i*FLIT_W +: FLIT_W] |
| credit_out | output | 5 | Credit returned upstream, one pulse per flit drained from input i |
| out_valid | output | 5 | One bit per output: a flit is on that output link |
| out_flit | output | 5*FLIT_W | Output flits, port o in bits [o*FLIT_W +: FLIT_W] |
| credit_in | input | 5 | Credit returned from the downstream buffer of output o |

## Verification
The bench uses the default build: 16-bit flits, 2-bit coordinates with the router at (1,1), 4-deep input FIFOs and 4 downstream credits. With these settings the sweep over all 16 destinations from all five inputs reaches every routing branch, and packet lengths from one to four flits reach every flit type. The shallow FIFOs and credit pools make back-pressure and credit exhaustion happen often. Five inputs contending for one output show the full round-robin rotation.

// File: rtl/wr_pkg.sv
package wr_pkg;
    localparam int NP = 5;
    localparam int P_LOCAL = 0;
    localparam int P_EAST  = 1;
    localparam int P_WEST  = 2;
    localparam int P_NORTH = 3;
    localparam int P_SOUTH = 4;

    typedef enum logic [1:0] {
        FT_HEAD   = 2'b00,
        FT_BODY   = 2'b01,
        FT_TAIL   = 2'b10,
        FT_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic {
        IN_IDLE   = 1'b0,
        IN_ACTIVE = 1'b1
    } in_state_e;
endpackage

// File: rtl/wr_fifo.sv
module wr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
            cnt <= cnt + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign rd_data = mem[rp];
    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
endmodule

// File: rtl/wr_route.sv
module wr_route import wr_pkg::*; #(
    parameter int COORD_W = 2,
    parameter int OWN_X   = 1,
    parameter int OWN_Y   = 1
) (
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    output logic [NP-1:0]      port_oh
);
    localparam logic [COORD_W-1:0] MX = COORD_W'(OWN_X);
    localparam logic [COORD_W-1:0] MY = COORD_W'(OWN_Y);

    always_comb begin
        port_oh = '0;
        if (dx > MX)      port_oh[P_EAST]  = 1'b1;
        else if (dx < MX) port_oh[P_WEST]  = 1'b1;
        else if (dy > MY) port_oh[P_NORTH] = 1'b1;
        else if (dy < MY) port_oh[P_SOUTH] = 1'b1;
        else              port_oh[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/wr_rr_arb.sv
module wr_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic          found;

    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                win      = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr <= '0;
        else if (found) ptr <= (int'(win) == N - 1) ? '0 : win + 1'b1;
    end
endmodule

// File: rtl/wormhole_router.sv
module wormhole_router import wr_pkg::*; #(
    parameter int FLIT_W     = 16,
    parameter int COORD_W    = 2,
    parameter int OWN_X      = 1,
    parameter int OWN_Y      = 1,
    parameter int FIFO_DEPTH = 4,
    parameter int CRED_INIT  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        in_valid,
    input  logic [NP*FLIT_W-1:0] in_flit,
    output logic [NP-1:0]        credit_out,
    output logic [NP-1:0]        out_valid,
    output logic [NP*FLIT_W-1:0] out_flit,
    input  logic [NP-1:0]        credit_in
);
    localparam int EW = NP + FLIT_W;
    localparam int CW = $clog2(CRED_INIT + 1);

    logic [NP-1:0] fifo_full, fifo_empty, pop, req, in_gnt, done;
    logic [NP-1:0] out_busy, cred_nz, send;
    logic [NP-1:0][NP-1:0] req_mat, gnt, own_mat;   // [output][input]
    logic [NP-1:0]     q_route [NP];
    logic [FLIT_W-1:0] q_flit  [NP];
    logic [NP-1:0]     lock_oh [NP];
    logic [FLIT_W-1:0] xbar    [NP];
    in_state_e         st      [NP];
    in_state_e         st_nx   [NP];

    // input side: buffer write and route compute in the same cycle
    for (genvar i = 0; i < NP; i++) begin : g_in
        logic [NP-1:0] rt_new;
        logic [EW-1:0] rd_w;
        flit_kind_e    kind;

        wr_route #(.COORD_W(COORD_W), .OWN_X(OWN_X), .OWN_Y(OWN_Y)) u_rt (
            .dx      (in_flit[i*FLIT_W +: COORD_W]),
            .dy      (in_flit[i*FLIT_W + COORD_W +: COORD_W]),
            .port_oh (rt_new)
        );

        wr_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (in_valid[i]),
            .wr_data ({rt_new, in_flit[i*FLIT_W +: FLIT_W]}),
            .rd_en   (pop[i]),
            .rd_data (rd_w),
            .empty   (fifo_empty[i]),
            .full    (fifo_full[i])
        );

        assign q_route[i] = rd_w[EW-1 -: NP];
        assign q_flit[i]  = rd_w[FLIT_W-1:0];
        assign kind       = flit_kind_e'(q_flit[i][FLIT_W-1 -: 2]);
        assign req[i]     = (st[i] == IN_IDLE) && !fifo_empty[i]
                            && (kind == FT_HEAD || kind == FT_SINGLE);
        assign pop[i]     = (st[i] == IN_ACTIVE) && !fifo_empty[i]
                            && |(lock_oh[i] & cred_nz);
        assign done[i]    = pop[i] && (kind == FT_TAIL || kind == FT_SINGLE);

        for (genvar o = 0; o < NP; o++) begin : g_x
            assign req_mat[o][i] = req[i] & q_route[i][o] & ~out_busy[o] & cred_nz[o];
            assign own_mat[o][i] = (st[i] == IN_ACTIVE) & lock_oh[i][o];
        end
    end

    // output side: allocator and credit counter per output
    for (genvar o = 0; o < NP; o++) begin : g_out
        logic [CW-1:0] cnt;

        wr_rr_arb #(.N(NP)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_mat[o]),
            .gnt   (gnt[o])
        );

        assign out_busy[o] = |own_mat[o];
        assign send[o]     = |(own_mat[o] & pop);
        assign cred_nz[o]  = (cnt != '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= CW'(CRED_INIT);
            else        cnt <= cnt - CW'(send[o]) + CW'(credit_in[o]);
        end
    end

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_gnt[i] = 1'b0;
            for (int o = 0; o < NP; o++) in_gnt[i] = in_gnt[i] | gnt[o][i];
        end
    end

    // next-state logic of the per-input machines
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            st_nx[i] = st[i];
            unique case (st[i])
                IN_IDLE:   if (in_gnt[i]) st_nx[i] = IN_ACTIVE;
                IN_ACTIVE: if (done[i])   st_nx[i] = IN_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                st[i]      <= IN_IDLE;
                lock_oh[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NP; i++) begin
                st[i] <= st_nx[i];
                if (st[i] == IN_IDLE && in_gnt[i]) lock_oh[i] <= q_route[i];
            end
        end
    end

    // crossbar
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            xbar[o] = '0;
            for (int i = 0; i < NP; i++)
                if (pop[i] && lock_oh[i][o]) xbar[o] = xbar[o] | q_flit[i];
        end
    end

    // outputs: link registers and upstream credits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_flit  <= '0;
        end else begin
            out_valid <= send;
            for (int o = 0; o < NP; o++) out_flit[o*FLIT_W +: FLIT_W] <= xbar[o];
        end
    end

    assign credit_out = pop;
endmodule

// File: rtl/wormhole_router_chk.sv
module wormhole_router_chk import wr_pkg::*; (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NP-1:0]         in_valid,
    input logic [NP-1:0]         fifo_full,
    input logic [NP-1:0][NP-1:0] gnt,
    input logic [NP-1:0][NP-1:0] own_mat,
    input logic [NP-1:0]         send,
    input logic [NP-1:0]         cred_nz,
    input logic [NP-1:0]         credit_out,
    input logic [NP-1:0]         out_valid
);
    // R8
    credit_matches_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(out_valid) == $countones($past(credit_out))));

    for (genvar k = 0; k < NP; k++) begin : g_k
        // R9
        fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[k] |-> !fifo_full[k]);
        // R6
        grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[k]));
        // R4
        single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own_mat[k]));
        // R7
        send_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            send[k] |-> cred_nz[k]);
    end
endmodule

bind wormhole_router wormhole_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .fifo_full  (fifo_full),
    .gnt        (gnt),
    .own_mat    (own_mat),
    .send       (send),
    .cred_nz    (cred_nz),
    .credit_out (credit_out),
    .out_valid  (out_valid)
);

// File: tb/wormhole_router_tb.sv
module wormhole_router_tb;
    localparam int FW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    in_valid = '0;
    logic [FW-1:0] drv_flit [5];
    logic [5*FW-1:0] in_flit;
    logic [4:0]    credit_out, out_valid;
    logic [5*FW-1:0] out_flit;
    logic [4:0]    credit_in = '0;

    int checks = 0, errors = 0;
    int bcred [5];
    int pend [5];
    bit auto_ret = 1'b1;
    bit finished = 1'b0;

    int flit_cnt [5], pkt_cnt [5], cout_cnt [5];
    bit inpkt [5];
    int cur_id [5], cur_seq [5];
    int log_src [32];
    int log_n = 0;
    bit log_en = 1'b0;

    always #5 clk = ~clk;

    assign in_flit = {drv_flit[4], drv_flit[3], drv_flit[2], drv_flit[1], drv_flit[0]};

    wormhole_router u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .credit_out(credit_out), .out_valid(out_valid), .out_flit(out_flit),
        .credit_in(credit_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_port(input int dx, input int dy);
        if (dx > 1) return 1;
        if (dx < 1) return 2;
        if (dy > 1) return 3;
        if (dy < 1) return 4;
        return 0;
    endfunction

    function automatic logic [FW-1:0] mk(input int kind, input int id, input int seq,
                                         input int dx, input int dy);
        return {kind[1:0], id[6:0], seq[2:0], dy[1:0], dx[1:0]};
    endfunction

    // upstream credit model and downstream credit return
    always @(posedge clk) begin
        for (int i = 0; i < 5; i++) begin
            if (!rst_n) begin
                bcred[i] <= 4;
                pend[i] = 0;
                credit_in[i] <= 1'b0;
            end else begin
                bcred[i] <= bcred[i] - int'(in_valid[i]) + int'(credit_out[i]);
                pend[i] = pend[i] + int'(out_valid[i]);
                if (auto_ret && pend[i] > 0) begin
                    credit_in[i] <= 1'b1;
                    pend[i] = pend[i] - 1;
                end else credit_in[i] <= 1'b0;
            end
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < 5; o++) begin
                cout_cnt[o] += int'(credit_out[o]);
                if (out_valid[o]) begin
                    logic [FW-1:0] f;
                    int kind, id, seq;
                    bit fin;
                    f = out_flit[o*FW +: FW];
                    kind = int'(f[15:14]); id = int'(f[13:7]); seq = int'(f[6:4]);
                    fin = 1'b0;
                    flit_cnt[o]++;
                    if (!inpkt[o]) begin
                        chk(kind == 0 || kind == 3, "R4 first flit of packet is a head", kind, 0);
                        chk(exp_port(int'(f[1:0]), int'(f[3:2])) == o, "R2 output port of head",
                            o, exp_port(int'(f[1:0]), int'(f[3:2])));
                        cur_id[o] = id; cur_seq[o] = seq;
                        if (kind == 0) inpkt[o] = 1'b1; else fin = 1'b1;
                    end else begin
                        chk(id == cur_id[o], "R4 packet id stays contiguous", id, cur_id[o]);
                        chk(seq == cur_seq[o] + 1, "R4 flit order", seq, cur_seq[o] + 1);
                        chk(kind == 1 || kind == 2, "R3 non-head type inside packet", kind, 1);
                        cur_seq[o] = seq;
                        if (kind == 2) begin inpkt[o] = 1'b0; fin = 1'b1; end
                    end
                    if (fin) begin
                        pkt_cnt[o]++;
                        if (o == 0 && log_en && log_n < 32) begin
                            log_src[log_n] = id / 16;
                            log_n++;
                        end
                    end
                end
            end
        end
    end

    task automatic send_pkt(input int s, input int dx, input int dy, input int len, input int id);
        for (int q = 0; q < len; q++) begin
            int kind;
            kind = (len == 1) ? 3 : (q == 0) ? 0 : (q == len - 1) ? 2 : 1;
            while (bcred[s] == 0) begin
                in_valid[s] = 1'b0;
                @(negedge clk);
            end
            in_valid[s] = 1'b1;
            drv_flit[s] = mk(kind, id, q, dx, dy);
            @(negedge clk);
        end
        in_valid[s] = 1'b0;
    endtask

    task automatic sweep_src(input int s);
        for (int d = 0; d < 16; d++) send_pkt(s, d % 4, d / 4, 1 + ((d + s) % 4), s * 16 + d);
    endtask

    task automatic contend_src(input int s);
        send_pkt(s, 1, 1, 3, s * 16);
        send_pkt(s, 1, 1, 3, s * 16 + 1);
    endtask

    function automatic int sum5(input int a [5]);
        int t = 0;
        for (int k = 0; k < 5; k++) t += a[k];
        return t;
    endfunction

    task automatic clear_counts();
        for (int k = 0; k < 5; k++) begin
            flit_cnt[k] = 0; pkt_cnt[k] = 0; cout_cnt[k] = 0;
        end
    endtask

    initial begin
        for (int k = 0; k < 5; k++) drv_flit[k] = '0;
        clear_counts();
        for (int k = 0; k < 5; k++) begin inpkt[k] = 1'b0; cur_id[k] = 0; cur_seq[k] = 0; end
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(credit_out == 0, "R1 credit_out in reset", int'(credit_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(credit_out == 0, "R1 credit_out after reset", int'(credit_out), 0);

        // R3 latency of a single-flit packet, input 1 to local
        in_valid[1] = 1'b1; drv_flit[1] = mk(3, 16, 0, 1, 1);
        @(negedge clk); in_valid[1] = 1'b0;
        chk(out_valid[0] == 0, "R3 no output at t+1", int'(out_valid[0]), 0);
        @(negedge clk);
        chk(credit_out[1] == 1, "R8 credit in traversal cycle t+2", int'(credit_out[1]), 1);
        chk(out_valid[0] == 0, "R3 no output at t+2", int'(out_valid[0]), 0);
        @(negedge clk);
        chk(out_valid[0] == 1, "R3 output at t+3", int'(out_valid[0]), 1);
        chk(out_flit[15:0] == mk(3, 16, 0, 1, 1), "R3 flit payload", int'(out_flit[15:0]),
            int'(mk(3, 16, 0, 1, 1)));
        repeat (10) @(negedge clk);

        // R2 R4 sweep over every destination from every input
        clear_counts();
        fork
            sweep_src(0); sweep_src(1); sweep_src(2); sweep_src(3); sweep_src(4);
        join
        repeat (60) @(negedge clk);
        begin
            int ef = 0;
            for (int s = 0; s < 5; s++)
                for (int d = 0; d < 16; d++) ef += 1 + ((d + s) % 4);
            chk(sum5(pkt_cnt) == 80, "R4 all sweep packets delivered", sum5(pkt_cnt), 80);
            chk(sum5(flit_cnt) == ef, "R4 all sweep flits delivered", sum5(flit_cnt), ef);
            chk(sum5(cout_cnt) == ef, "R8 one credit per drained flit", sum5(cout_cnt), ef);
        end

        // R5 R6 contention for the local output
        clear_counts();
        log_n = 0; log_en = 1'b1;
        fork
            contend_src(0); contend_src(1); contend_src(2); contend_src(3); contend_src(4);
        join
        repeat (60) @(negedge clk);
        log_en = 1'b0;
        chk(pkt_cnt[0] == 10, "R5 all contending packets delivered", pkt_cnt[0], 10);
        begin
            bit [4:0] seen = '0;
            for (int k = 0; k < 5 && k < log_n; k++) seen[log_src[k]] = 1'b1;
            chk(seen == 5'b11111, "R6 round-robin serves each input once first", int'(seen), 31);
        end

        // R7 R9 credit exhaustion on the east output
        clear_counts();
        auto_ret = 1'b0;
        send_pkt(2, 3, 1, 8, 99);
        repeat (40) @(negedge clk);
        chk(flit_cnt[1] == 4, "R7 flits sent without credit return", flit_cnt[1], 4);
        chk(cout_cnt[2] == 4, "R8 credits while output stalled", cout_cnt[2], 4);
        auto_ret = 1'b1;
        repeat (60) @(negedge clk);
        chk(flit_cnt[1] == 8, "R9 stalled packet delivered intact", flit_cnt[1], 8);
        chk(pkt_cnt[1] == 1, "R7 packet completes after credit return", pkt_cnt[1], 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule